// File: doc/BRIEF.md
# Integer ALU with Flag Update

This block is the arithmetic and logic stage of a processor datapath. Each cycle it takes a first operand, a second operand that an upstream shifter has already shifted, an opcode, a set-flags request, the current NZCV flags and the shifter's carry-out. It computes one of sixteen data operations. One clock edge later it presents the result, a write-enable for the destination register and the next NZCV flags.

There are six arithmetic operations: add, add with carry, subtract, subtract with carry, and reverse subtract with and without carry. They all share one adder, which steers and inverts its operands. Subtraction reports carry as "no borrow", so a chain of subtract-with-carry operations builds multi-word differences. Six logical and move operations take their carry flag from the shifter and leave the overflow flag alone. Four compare and test operations always update the flags and never request a register write. Condition evaluation and the register file sit outside the block.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 0 (add) yields a+b and opcode 1 (add with carry) yields a+b+C, where C is bit 1 of the incoming flags. Results are modulo 2^DW.
- R2: Opcode 2 (subtract) yields a-b and opcode 3 (subtract with carry) yields a-b+C-1.
- R3: Opcode 4 (reverse subtract) yields b-a and opcode 5 (reverse subtract with carry) yields b-a+C-1.
- R4: The logical and move opcodes give the following results: opcode 6 gives a AND b, 7 gives a OR b, 8 gives a XOR b, 9 gives a AND NOT b, 10 gives b, and 11 gives NOT b.
- R5: The flag vector is ordered N (bit 3), Z (bit 2), C (bit 1), V (bit 0). When the flags update, N equals the result's MSB and Z is set exactly when the result is zero.
- R6: When an arithmetic or compare-arithmetic opcode updates the flags, C is the carry out of the MSB. For additions this means the unsigned sum reached 2^DW; for subtractions it means no borrow. V is set on signed overflow.
- R7: When a logical, move or test opcode updates the flags, C equals the shifter carry input and V keeps its incoming value.
- R8: Opcode 12 (compare, a-b), 13 (compare negated, a+b), 14 (equality test, a XOR b) and 15 (bit test, a AND b) update the flags whatever the set-flags input is, and they hold write-enable low. Opcodes 0 to 11 raise write-enable.
- R9: For opcodes 0 to 11 with set-flags low, the next flags equal the incoming flags unchanged.
- R10: Result, write-enable and flags are registered and appear one clock after the inputs. A synchronous active-low reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request a flag update for opcodes 0 to 11 |
| flags_i | input | 4 | Current N,Z,C,V flags |
| shift_c_i | input | 1 | Carry-out of the upstream shifter |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand, already shifted |
| result_o | output | DW | Registered result |
| wr_en_o | output | 1 | Registered destination write-enable |
| flags_o | output | 4 | Registered next N,Z,C,V flags |

## Verification
Some properties hold on every clock and the assertions check them there. Compare and test opcodes never raise write-enable. Flags pass through untouched when no update is requested. N and Z always agree with the registered result when an update happens. Logical updates copy the shifter carry and keep V. Reset clears every output. The values themselves can only be shown by the bench's exhaustive sweep of a 4-bit instance. That covers every opcode, every pair of operands, both carry-in values and both set-flags settings, with the result, carry and overflow compared against integer arithmetic.

// File: rtl/alu_pkg.sv
// Shared types for the integer ALU: opcode encoding and flag vector layout.
// Assumes a 4-bit opcode; flag vector order N,Z,C,V from MSB to LSB.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_RSC = 4'd5,
        OP_AND = 4'd6,
        OP_ORR = 4'd7,
        OP_EOR = 4'd8,
        OP_BIC = 4'd9,
        OP_MOV = 4'd10,
        OP_MVN = 4'd11,
        OP_CMP = 4'd12,
        OP_CMN = 4'd13,
        OP_TEQ = 4'd14,
        OP_TST = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // True for opcodes that only set flags and never write a result
    function automatic logic op_is_cmp(alu_op_e op);
        return op inside {OP_CMP, OP_CMN, OP_TEQ, OP_TST};
    endfunction

    // True for opcodes served by the adder
    function automatic logic op_is_arith(alu_op_e op);
        return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC,
                          OP_CMP, OP_CMN};
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Shared adder for all arithmetic opcodes. Subtraction is done as
// x + ~y + cin, so carry out means "no borrow". Overflow is the XOR of
// the carries into and out of the MSB. Assumes DW >= 2.
module alu_addsub
    import alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           c_in_flag,
    output logic [DW-1:0]  sum,
    output logic           c_out,
    output logic           v_out
);
    localparam int LW = DW - 1;

    logic [DW-1:0] x_op;
    logic [DW-1:0] y_op;
    logic          cin;
    logic [DW:0]   full_sum;
    logic [LW:0]   low_sum;

    // Steer, invert and pick carry-in for the requested operation
    always_comb begin
        x_op = a;
        y_op = b;
        cin  = 1'b0;
        case (op)
            OP_ADC:          cin = c_in_flag;
            OP_SUB, OP_CMP: begin y_op = ~b; cin = 1'b1; end
            OP_SBC:          begin y_op = ~b; cin = c_in_flag; end
            OP_RSB:          begin x_op = b; y_op = ~a; cin = 1'b1; end
            OP_RSC:          begin x_op = b; y_op = ~a; cin = c_in_flag; end
            default:         ;
        endcase
    end

    // Full-width sum plus the sum of the lower bits for carry into the MSB
    always_comb begin
        full_sum = {1'b0, x_op} + {1'b0, y_op} + {{DW{1'b0}}, cin};
        low_sum  = {1'b0, x_op[LW-1:0]} + {1'b0, y_op[LW-1:0]} + {{LW{1'b0}}, cin};
    end

    assign sum   = full_sum[DW-1:0];
    assign c_out = full_sum[DW];
    assign v_out = low_sum[LW] ^ full_sum[DW];

endmodule

// File: rtl/alu_logic.sv
// Bitwise unit for logical, move and test opcodes. Produces zero for
// opcodes it does not serve; the top selects between this and the adder.
module alu_logic
    import alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y
);
    // Bitwise function per opcode
    always_comb begin
        case (op)
            OP_AND, OP_TST: y = a & b;
            OP_ORR:         y = a | b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_BIC:         y = a & ~b;
            OP_MOV:         y = b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
// Next-flag logic. N and Z come from the result; C and V from the adder
// for arithmetic opcodes; C from the shifter and V held for the others.
// Flags move only on set-flags or a compare/test opcode.
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e        op,
    input  logic           set_flags,
    input  nzcv_t          flags_in,
    input  logic [DW-1:0]  res,
    input  logic           add_c,
    input  logic           add_v,
    input  logic           shift_c,
    output nzcv_t          flags_next
);
    logic  upd;
    nzcv_t computed;

    // Build the candidate flags for this opcode class
    always_comb begin
        computed.n = res[DW-1];
        computed.z = (res == '0);
        if (op_is_arith(op)) begin
            computed.c = add_c;
            computed.v = add_v;
        end else begin
            computed.c = shift_c;
            computed.v = flags_in.v;
        end
    end

    // Apply the candidate only when an update is requested
    always_comb begin
        upd        = set_flags | op_is_cmp(op);
        flags_next = upd ? computed : flags_in;
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Top of the integer ALU: combines adder and bitwise unit, generates the
// next flags and the write-enable, and registers all outputs one cycle
// after the inputs. Assumes the second operand arrives already shifted.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic           set_flags_i,
    input  logic [3:0]     flags_i,
    input  logic           shift_c_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output logic [DW-1:0]  result_o,
    output logic           wr_en_o,
    output logic [3:0]     flags_o
);
    alu_op_e       op;
    logic [DW-1:0] add_sum;
    logic          add_c;
    logic          add_v;
    logic [DW-1:0] log_y;
    logic [DW-1:0] res_c;
    nzcv_t         flags_next;
    logic          wr_c;

    assign op = alu_op_e'(op_i);

    alu_addsub #(.DW(DW)) u_addsub (
        .op        (op),
        .a         (a_i),
        .b         (b_i),
        .c_in_flag (flags_i[1]),
        .sum       (add_sum),
        .c_out     (add_c),
        .v_out     (add_v)
    );

    alu_logic #(.DW(DW)) u_logic (
        .op (op),
        .a  (a_i),
        .b  (b_i),
        .y  (log_y)
    );

    alu_flag_gen #(.DW(DW)) u_flags (
        .op         (op),
        .set_flags  (set_flags_i),
        .flags_in   (nzcv_t'(flags_i)),
        .res        (res_c),
        .add_c      (add_c),
        .add_v      (add_v),
        .shift_c    (shift_c_i),
        .flags_next (flags_next)
    );

    // Select the unit that serves this opcode and derive the write-enable
    always_comb begin
        res_c = op_is_arith(op) ? add_sum : log_y;
        wr_c  = ~op_is_cmp(op);
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= 4'b0;
        end else begin
            result_o <= res_c;
            wr_en_o  <= wr_c;
            flags_o  <= flags_next;
        end
    end

    // R8: compare/test opcodes never request a write; others always do
    a_r8_write_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_en_o == !op_is_cmp(alu_op_e'($past(op_i)))));

    // R9: no update requested means flags pass through unchanged
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags_i && !op_is_cmp(op)) |=> (flags_o == $past(flags_i)));

    // R5: N tracks the registered result's MSB on an update
    a_r5_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i || op_is_cmp(op)) |=> (flags_o[3] == result_o[DW-1]));

    // R5: Z tracks an all-zero registered result on an update
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i || op_is_cmp(op)) |=> (flags_o[2] == (result_o == '0)));

    // R7: non-arithmetic updates copy the shifter carry
    a_r7_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_flags_i || op_is_cmp(op)) && !op_is_arith(op))
        |=> (flags_o[1] == $past(shift_c_i)));

    // R7: non-arithmetic updates keep V
    a_r7_keep_v: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_flags_i || op_is_cmp(op)) && !op_is_arith(op))
        |=> (flags_o[0] == $past(flags_i[0])));

    // R10: reset clears every output on the next edge
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !wr_en_o && flags_o == 4'b0));

endmodule

// File: tb/alu_flag_unit_tb.sv
// Exhaustive sweep of a 4-bit instance: every opcode, operand pair,
// carry-in and set-flags value, checked against integer arithmetic.
module alu_flag_unit_tb;
    localparam int DW = 4;
    localparam int MASK = (1 << DW) - 1;
    localparam int HALF = 1 << (DW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = '0;
    logic          set_flags_i = 1'b0;
    logic [3:0]    flags_i = '0;
    logic          shift_c_i = 1'b0;
    logic [DW-1:0] a_i = '0;
    logic [DW-1:0] b_i = '0;
    logic [DW-1:0] result_o;
    logic          wr_en_o;
    logic [3:0]    flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_flag_unit #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
        .flags_i(flags_i), .shift_c_i(shift_c_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    function automatic int sx(int v);
        return (v >= HALF) ? v - (1 << DW) : v;
    endfunction

    // Reference model from the requirements, in plain integers
    task automatic model(input int op, a, b, fl_in, sc, se,
                         output int r, wr, fl);
        int t, sv, c, v, n, z, cf, logic_op;
        cf = (fl_in >> 1) & 1;
        logic_op = 0; t = 0; sv = 0;
        case (op)
            0, 13: begin t = a + b;             sv = sx(a) + sx(b); end
            1:     begin t = a + b + cf;        sv = sx(a) + sx(b) + cf; end
            2, 12: begin t = a - b;             sv = sx(a) - sx(b); end
            3:     begin t = a - b + cf - 1;    sv = sx(a) - sx(b) + cf - 1; end
            4:     begin t = b - a;             sv = sx(b) - sx(a); end
            5:     begin t = b - a + cf - 1;    sv = sx(b) - sx(a) + cf - 1; end
            6, 15: begin t = a & b;  logic_op = 1; end
            7:     begin t = a | b;  logic_op = 1; end
            8, 14: begin t = a ^ b;  logic_op = 1; end
            9:     begin t = a & ~b; logic_op = 1; end
            10:    begin t = b;      logic_op = 1; end
            default: begin t = ~b;   logic_op = 1; end
        endcase
        r = t & MASK;
        if (logic_op) begin
            c = sc;
            v = fl_in & 1;
        end else begin
            if (op inside {0, 1, 13}) c = (t > MASK) ? 1 : 0;
            else                      c = (t >= 0) ? 1 : 0;
            v = (sv > HALF - 1 || sv < -HALF) ? 1 : 0;
        end
        n = (r >> (DW - 1)) & 1;
        z = (r == 0) ? 1 : 0;
        wr = (op < 12) ? 1 : 0;
        if (se != 0 || op >= 12) fl = n * 8 + z * 4 + c * 2 + v;
        else                     fl = fl_in;
    endtask

    function automatic string res_tag(int op);
        if (op <= 1) return "R1";
        if (op <= 3) return "R2";
        if (op <= 5) return "R3";
        if (op <= 11) return "R4";
        return "R8";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input int op,
                         input int a, input int b);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%0d b=%0d actual=%0h expected=%0h",
                     tag, op, a, b, act, exp);
        end
    endtask

    initial begin
        // R10: reset clears all outputs while inputs are busy
        op_i = 4'd10; b_i = 4'hF; a_i = 4'h5; set_flags_i = 1'b1; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        check("R10", result_o, 0, 10, 5, 15);
        check("R10", wr_en_o, 0, 10, 5, 15);
        check("R10", flags_o, 0, 10, 5, 15);
        rst_n = 1'b1;

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    for (int k = 0; k < 4; k++) begin
                        int se, fl_in, sc, er, ew, ef, upd;
                        se = k & 1;
                        fl_in = ((a & 1) << 3) | (((b >> 1) & 1) << 2)
                              | (((k >> 1) & 1) << 1) | (((a ^ b) >> 2) & 1);
                        sc = (a + b + op) & 1;
                        op_i = op[3:0]; a_i = a[DW-1:0]; b_i = b[DW-1:0];
                        set_flags_i = se[0]; flags_i = fl_in[3:0]; shift_c_i = sc[0];
                        model(op, a, b, fl_in, sc, se, er, ew, ef);
                        // R10: outputs sampled one edge after the inputs
                        @(negedge clk);
                        upd = (se != 0 || op >= 12) ? 1 : 0;
                        check(res_tag(op), result_o, er, op, a, b);
                        check("R8", wr_en_o, ew, op, a, b);
                        // R5: N and Z bits
                        check(upd ? "R5" : "R9", flags_o[3:2], (ef >> 2) & 3, op, a, b);
                        // R6 arithmetic C/V, R7 logical C/V, R9 hold
                        check(!upd ? "R9" : ((op >= 6 && op <= 11) || op >= 14) ? "R7" : "R6",
                              flags_o[1:0], ef & 3, op, a, b);
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule